// File: doc/BRIEF.md
# Dual-Input Capture and Output-Compare Timer

The block is a free-running up-counter with two edge-triggered capture channels and one compare-driven output. Each channel watches an external pin and copies the running count into its own capture register when the selected edge arrives. Channel 1 can also restart the counter from zero on its event. This lets software read a period or pulse width directly from capture register 1.

A tie option makes channel 2 listen to the channel 1 pin instead of its own pin. With opposite edges selected on the two channels, high time and period come from a single signal. A compare register toggles the output one count before the count reaches the compare value. Software command bits can force the output high or low while the output is enabled.

Four sticky flags record capture 1, capture 2, compare and overflow events. Each flag has its own enable. Together they produce a single interrupt request, which is also gated by the global timer enable.

Top module: `capcmp_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count`, both capture values, `flags`, `cmp_out` and `irq` are all zero.
- R2: With `tmr_en` high, `count` rises by one each clock and wraps from 0xFFFF to 0. The wrap sets flag bit 3 (overflow). With `tmr_en` low, `count` holds.
- R3: Each channel has a 2-bit edge select: 00 disables the channel, 01 selects rising edges, 10 falling edges and 11 both edges. The pin passes through a two-flop synchronizer. If a pin changes when `count` reads c, the capture register holds c+2 three clocks later. Events occur only while `tmr_en` is high. Flag bit 0 marks a capture 1 event and flag bit 1 a capture 2 event.
- R4: With `cap1_rst_en` high, a channel 1 event stores the count as it stood before that clock. On the same clock `count` becomes 0.
- R5: With `tie_inputs` high, channel 2 samples `cap1_pin` and ignores `cap2_pin`.
- R6: When `count` equals `cmp_val` minus one (modulo 2^16) while enabled, the output state toggles on the next clock. The same event sets flag bit 2.
- R7: `out_set_cmd` forces the output state to 1 and `out_clr_cmd` forces it to 0. Both act only while `out_en` is high. Set beats clear, and a command beats a compare toggle. `cmp_out` is low whenever `out_en` is low.
- R8: Writing 1 to a bit of `flag_clr` clears that flag on the next clock. An event in the same cycle as its clear leaves the flag set. A flag with no clear stays set.
- R9: `irq` is high exactly when `tmr_en` is high and some flag is set together with its bit in `irq_en`. A flag left set makes `irq` return as soon as its enable is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Global enable for counting, events and interrupt |
| cap1_pin | input | 1 | Asynchronous capture pin, channel 1 |
| cap2_pin | input | 1 | Asynchronous capture pin, channel 2 |
| cap1_edge | input | 2 | Channel 1 edge select |
| cap2_edge | input | 2 | Channel 2 edge select |
| cap1_rst_en | input | 1 | Channel 1 event restarts the counter |
| tie_inputs | input | 1 | Channel 2 samples the channel 1 pin |
| cmp_val | input | 16 | Compare value |
| out_en | input | 1 | Output enable |
| out_set_cmd | input | 1 | Force output high (one-cycle command) |
| out_clr_cmd | input | 1 | Force output low (one-cycle command) |
| irq_en | input | 4 | Per-flag interrupt enables |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| count | output | 16 | Running count |
| cap1_val | output | 16 | Capture register 1 |
| cap2_val | output | 16 | Capture register 2 |
| cmp_out | output | 1 | Compare output |
| flags | output | 4 | Sticky flags: 0 cap1, 1 cap2, 2 compare, 3 overflow |
| irq | output | 1 | Interrupt request |

## Verification
Some relations hold on every clock, and the embedded properties check those. A capture register loads the count it saw and otherwise holds. The counter holds when disabled, clears on a restart event and wraps to zero. A compare hit with no command flips the output, and without a hit the output state does not move while disabled. A raised event always lands in its flag, and an uncleared flag stays set. Other behaviour depends on a whole sequence of inputs, and only the bench scenarios can show it. This covers the exact two-clock synchronizer offset in captured values, the pin substitution under the tie option, and the compare toggle appearing one count early. It also covers the interrupt returning on re-enable and the overflow after a full 65536-count run.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    parameter int unsigned CNT_W    = 16;
    parameter int unsigned N_SRC    = 4;
    parameter int unsigned SYNC_LEN = 2;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // bit 0 cap1, bit 1 cap2, bit 2 compare, bit 3 overflow
    typedef struct packed {
        logic ovf;
        logic cmp;
        logic cap2;
        logic cap1;
    } evt_t;

    function automatic logic edge_hit(input logic cur, input logic prev, input edge_sel_e sel);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/capcmp_edge_cap.sv
module capcmp_edge_cap
    import capcmp_pkg::*;
#(
    parameter int unsigned W     = CNT_W,
    parameter int unsigned STAGE = SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         pin,
    input  edge_sel_e    sel,
    input  logic [W-1:0] cnt_in,
    output logic         evt,
    output logic [W-1:0] cap_q
);

    logic [STAGE:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[STAGE-1:0], pin};
    end

    assign evt = en & edge_hit(shift_q[STAGE-1], shift_q[STAGE], sel);

    always_ff @(posedge clk) begin
        if (rst)      cap_q <= '0;
        else if (evt) cap_q <= cnt_in;
    end

    a_r3_cap_load: assert property (@(posedge clk) disable iff (rst)
        evt |=> cap_q == $past(cnt_in));
    a_r3_cap_hold: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cap_q));

endmodule

// File: rtl/capcmp_counter.sv
module capcmp_counter
    import capcmp_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clr,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);

    localparam logic [W-1:0] TOP = '1;

    assign wrap = en & ~clr & (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (en) begin
            if (clr)    cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);
    a_r4_clr_zero: assert property (@(posedge clk) disable iff (rst)
        (en && clr) |=> cnt_q == '0);

endmodule

// File: rtl/capcmp_irq.sv
module capcmp_irq
    import capcmp_pkg::*;
#(
    parameter int unsigned N = N_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags_q,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr) | evt;
    end

    assign irq = en & (|(flags_q & ie));

    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (|(flags_q & ~clr)) |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_en,
    input  logic             cap1_pin,
    input  logic             cap2_pin,
    input  logic [1:0]       cap1_edge,
    input  logic [1:0]       cap2_edge,
    input  logic             cap1_rst_en,
    input  logic             tie_inputs,
    input  logic [W-1:0]     cmp_val,
    input  logic             out_en,
    input  logic             out_set_cmd,
    input  logic             out_clr_cmd,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [N_SRC-1:0] flag_clr,
    output logic [W-1:0]     count,
    output logic [W-1:0]     cap1_val,
    output logic [W-1:0]     cap2_val,
    output logic             cmp_out,
    output logic [N_SRC-1:0] flags,
    output logic             irq
);

    localparam int unsigned N_CH = 2;
    localparam logic [W-1:0] ONE = W'(1);

    logic [N_CH-1:0] ch_pin;
    edge_sel_e       ch_sel [N_CH];
    logic [W-1:0]    ch_cap [N_CH];
    logic [N_CH-1:0] ch_evt;
    logic            ovf_evt;
    logic            cmp_hit;
    logic            out_q;
    logic            force_set;
    logic            force_clr;
    evt_t            events;

    assign ch_pin[0] = cap1_pin;
    assign ch_pin[1] = tie_inputs ? cap1_pin : cap2_pin;
    assign ch_sel[0] = edge_sel_e'(cap1_edge);
    assign ch_sel[1] = edge_sel_e'(cap2_edge);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        capcmp_edge_cap #(.W(W), .STAGE(SYNC_LEN)) u_cap (
            .clk    (clk),
            .rst    (rst),
            .en     (tmr_en),
            .pin    (ch_pin[g]),
            .sel    (ch_sel[g]),
            .cnt_in (count),
            .evt    (ch_evt[g]),
            .cap_q  (ch_cap[g])
        );
    end

    assign cap1_val = ch_cap[0];
    assign cap2_val = ch_cap[1];

    capcmp_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (tmr_en),
        .clr   (ch_evt[0] & cap1_rst_en),
        .cnt_q (count),
        .wrap  (ovf_evt)
    );

    assign cmp_hit   = tmr_en & (count == (cmp_val - ONE));
    assign force_set = out_en & out_set_cmd;
    assign force_clr = out_en & out_clr_cmd;

    always_ff @(posedge clk) begin
        if (rst)            out_q <= 1'b0;
        else if (force_set) out_q <= 1'b1;
        else if (force_clr) out_q <= 1'b0;
        else if (cmp_hit)   out_q <= ~out_q;
    end

    assign cmp_out = out_en & out_q;

    assign events.cap1 = ch_evt[0];
    assign events.cap2 = ch_evt[1];
    assign events.cmp  = cmp_hit;
    assign events.ovf  = ovf_evt;

    capcmp_irq #(.N(N_SRC)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .en      (tmr_en),
        .evt     (events),
        .clr     (flag_clr),
        .ie      (irq_en),
        .flags_q (flags),
        .irq     (irq)
    );

    a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
        (cmp_hit && !force_set && !force_clr) |=> out_q != $past(out_q));
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        force_set |=> out_q);
    a_r7_ignored: assert property (@(posedge clk) disable iff (rst)
        (!out_en && !cmp_hit) |=> $stable(out_q));

endmodule

// File: tb/test_capcmp_timer.sv
`timescale 1ns/100ps
module test_capcmp_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_en = 0, cap1_pin = 0, cap2_pin = 0;
    logic [1:0]  cap1_edge = 0, cap2_edge = 0;
    logic        cap1_rst_en = 0, tie_inputs = 0;
    logic [15:0] cmp_val = 0;
    logic        out_en = 0, out_set_cmd = 0, out_clr_cmd = 0;
    logic [3:0]  irq_en = 0, flag_clr = 0;
    logic [15:0] count, cap1_val, cap2_val;
    logic        cmp_out, irq;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    capcmp_timer i_capcmp_timer (
        .clk(clk), .rst(rst), .tmr_en(tmr_en), .cap1_pin(cap1_pin), .cap2_pin(cap2_pin),
        .cap1_edge(cap1_edge), .cap2_edge(cap2_edge), .cap1_rst_en(cap1_rst_en),
        .tie_inputs(tie_inputs), .cmp_val(cmp_val), .out_en(out_en),
        .out_set_cmd(out_set_cmd), .out_clr_cmd(out_clr_cmd), .irq_en(irq_en),
        .flag_clr(flag_clr), .count(count), .cap1_val(cap1_val), .cap2_val(cap2_val),
        .cmp_out(cmp_out), .flags(flags), .irq(irq)
    );

    // reference model built from the requirements
    logic [15:0] m_cnt, m_cap1, m_cap2;
    logic [1:0]  m_s1, m_s2, m_s3;
    logic        m_out;
    logic [3:0]  m_flags;

    function automatic logic ref_edge(input logic cur, input logic prev, input logic [1:0] sel);
        case (sel)
            2'b01:   return cur && !prev;
            2'b10:   return !cur && prev;
            2'b11:   return cur != prev;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic e1, e2, hit, wr;
        if (rst) begin
            m_cnt <= 0; m_cap1 <= 0; m_cap2 <= 0; m_out <= 0; m_flags <= 0;
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
        end else begin
            e1  = tmr_en && ref_edge(m_s2[0], m_s3[0], cap1_edge);
            e2  = tmr_en && ref_edge(m_s2[1], m_s3[1], cap2_edge);
            hit = tmr_en && (m_cnt == cmp_val - 16'd1);
            wr  = tmr_en && !(e1 && cap1_rst_en) && (m_cnt == 16'hFFFF);
            m_s1 <= {(tie_inputs ? cap1_pin : cap2_pin), cap1_pin};
            m_s2 <= m_s1;
            m_s3 <= m_s2;
            if (tmr_en) m_cnt <= (e1 && cap1_rst_en) ? 16'd0 : m_cnt + 16'd1;
            if (e1) m_cap1 <= m_cnt;
            if (e2) m_cap2 <= m_cnt;
            if (out_en && out_set_cmd)      m_out <= 1'b1;
            else if (out_en && out_clr_cmd) m_out <= 1'b0;
            else if (hit)                   m_out <= ~m_out;
            m_flags <= (m_flags & ~flag_clr) | {wr, hit, e2, e1};
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            chk("R2", "count",   count,    m_cnt);
            chk("R3", "cap1",    cap1_val, m_cap1);
            chk("R3", "cap2",    cap2_val, m_cap2);
            chk("R8", "flags",   flags,    m_flags);
            chk("R6", "cmp_out", cmp_out,  out_en & m_out);
            chk("R9", "irq",     irq,      tmr_en & (|(m_flags & irq_en)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [15:0] c, b;
        void'($urandom(32'd1234));
        tick(3);
        #1;
        chk("R1", "count reset", count, 0);
        chk("R1", "cap reset", {cap1_val, cap2_val}, 0);
        chk("R1", "flags reset", flags, 0);
        chk("R1", "out/irq reset", {cmp_out, irq}, 0);
        tick(1); rst = 0;
        #1;
        chk("R1", "first cycle count", count, 0);
        tick(1); tmr_en = 1;
        tick(10); #1;
        chk("R2", "count after 10", count, 10);

        // R3 rising capture, offset of two counts
        tick(1); cap1_edge = 2'b01;
        tick(1); c = m_cnt; cap1_pin = 1;
        tick(3); #1;
        chk("R3", "rise capture", cap1_val, c + 16'd2);
        chk("R3", "cap1 flag", flags[0], 1);
        tick(1); b = m_cap1; cap1_pin = 0;
        tick(4); #1;
        chk("R3", "falling ignored on rise select", cap1_val, b);

        // R4 restart on capture
        tick(1); cap1_rst_en = 1; cap1_edge = 2'b11;
        tick(1); c = m_cnt; cap1_pin = 1;
        tick(3); #1;
        chk("R4", "pre-reset value", cap1_val, c + 16'd2);
        chk("R4", "count cleared", count, 0);
        tick(1); cap1_rst_en = 0; cap1_pin = 0;
        tick(4);

        // R5 tie option
        tie_inputs = 1; cap2_edge = 2'b01;
        tick(4); b = m_cap2; cap2_pin = 1;
        tick(4); #1;
        chk("R5", "own pin ignored when tied", cap2_val, b);
        tick(1); c = m_cnt; cap1_pin = 1;
        tick(3); #1;
        chk("R5", "tied capture", cap2_val, c + 16'd2);
        tick(1); tie_inputs = 0; cap2_edge = 2'b00; cap2_pin = 0;
        tick(4);

        // R6 compare one count early
        out_en = 1; out_clr_cmd = 1;
        tick(1); out_clr_cmd = 0; c = m_cnt; cmp_val = c + 16'd6;
        tick(5); #1;
        chk("R6", "no toggle before compare-1", cmp_out, 0);
        tick(1); #1;
        chk("R6", "toggle at compare", cmp_out, 1);
        chk("R6", "compare flag", flags[2], 1);

        // R7 commands ignored while disabled
        tick(1); cmp_val = m_cnt + 16'd2000; out_clr_cmd = 1;
        tick(1); out_clr_cmd = 0; out_en = 0; out_set_cmd = 1;
        tick(1); out_set_cmd = 0; #1;
        chk("R7", "gated output", cmp_out, 0);
        tick(1); out_en = 1; #1;
        chk("R7", "set ignored when disabled", cmp_out, 0);
        tick(1); out_set_cmd = 1; out_clr_cmd = 1;
        tick(1); out_set_cmd = 0; out_clr_cmd = 0; #1;
        chk("R7", "set beats clear", cmp_out, 1);

        // R8 clear collides with a new event
        tick(1); flag_clr = 4'hF;
        tick(1); flag_clr = 0;
        tick(1); cap1_pin = 0;
        tick(2); flag_clr = 4'hF;
        tick(1); flag_clr = 0; #1;
        chk("R8", "event beats clear", flags, 4'b0001);
        tick(1); flag_clr = 4'b0001;
        tick(1); flag_clr = 0; #1;
        chk("R8", "write one clears", flags[0], 0);

        // R9 interrupt gating and return
        tick(1); cap1_pin = 1;
        tick(3); irq_en = 4'b0001; #1;
        chk("R9", "irq raised", irq, 1);
        tick(1); irq_en = 0; #1;
        chk("R9", "irq off with enable", irq, 0);
        tick(1); irq_en = 4'b0001; #1;
        chk("R9", "irq returns", irq, 1);
        tick(1); tmr_en = 0; #1;
        chk("R9", "irq off with timer", irq, 0);
        tick(1); tmr_en = 1; #1;
        chk("R9", "irq back with timer", irq, 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            tick(1);
            tmr_en = ($urandom % 10) != 0;
            if ($urandom % 16 == 0) cap1_pin = ~cap1_pin;
            if ($urandom % 16 == 0) cap2_pin = ~cap2_pin;
            if ($urandom % 64 == 0) cap1_edge = 2'($urandom);
            if ($urandom % 64 == 0) cap2_edge = 2'($urandom);
            if ($urandom % 64 == 0) tie_inputs = ($urandom % 3) == 0;
            if ($urandom % 64 == 0) cap1_rst_en = ($urandom % 4) != 0;
            if ($urandom % 32 == 0) cmp_val = 16'($urandom % 48);
            if ($urandom % 32 == 0) out_en = ($urandom % 4) != 0;
            out_set_cmd = ($urandom % 10) == 0;
            out_clr_cmd = ($urandom % 10) == 0;
            flag_clr = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
            if ($urandom % 32 == 0) irq_en = 4'($urandom);
        end

        // R2 full wrap
        tick(1); tmr_en = 1; cap1_rst_en = 0; out_set_cmd = 0; out_clr_cmd = 0;
        cap1_edge = 0; cap2_edge = 0; flag_clr = 4'hF;
        tick(1); flag_clr = 0;
        tick(66000); #1;
        chk("R2", "overflow flag", flags[3], 1);
        tick(1);
        finish_run();
    end

endmodule